// File: doc/BRIEF.md
# Two-Channel Coincidence Histogrammer with Rate Meter

This block sits behind two pulse-height extractors that run in lock-step on a shared sample strobe. On every accepted sample each extractor presents an amplitude, and a value of zero means that no pulse ended on that sample. The block scales each amplitude by a fixed divisor and adds one count to a per-channel spectrum held in on-chip RAM. When both channels report a pulse on the same sample, it also bins the pair, at a coarser scale, into a two-dimensional coincidence matrix.

A rate meter runs alongside the histograms. Over a fixed window of accepted samples it counts the strong pulses on each channel and the strong coincidences. At the end of each window it publishes the three counts together with a one-cycle strobe, then starts the next window from zero.

While acquisition is paused, a host reads the spectra and the matrix through an address-based readout port. The same port can zero each entry right after reading it, so one pass dumps the contents and prepares the RAMs for the next run.

Top module: `coinc_hist`

## Requirements
- R1: For each channel the bin index is amplitude / SGL_DIV (integer division, default 100). The sample adds one to that channel's bin only when the index is greater than 0 and smaller than SGL_BINS.
- R2: A coincidence needs both amplitudes to be nonzero on the same accepted sample. Its coordinates are x = amp_a / COIN_DIV and y = amp_b / COIN_DIV (default 1500). The pair is binned only when both x and y are smaller than COIN_DIM, and it lands at matrix address x*COIN_DIM + y.
- R3: Every bin saturates at 2^CNT_W - 1 and never wraps.
- R4: Hits on the same bin in consecutive cycles are all counted, with none lost.
- R5: The rate count of a channel grows by one for each accepted sample whose single-channel index exceeds SGL_RATE_MIN (default 60), whether or not that index falls inside the histogram.
- R6: The coincidence rate count grows only when both coordinates exceed COIN_RATE_MIN (default 6).
- R7: After every RATE_PERIOD accepted samples, rate_a, rate_b and rate_c take the totals of that window on the next clock edge. The totals include the last sample of the window. rate_stb is high for exactly that one cycle, and counting restarts from zero.
- R8: A sample is accepted only when acq_en and smp_vld are both high. Any other sample changes no bin, no rate count and no window position.
- R9: A read is a one-cycle rd_en pulse with rd_sel (0 = channel A, 1 = channel B, 2 = matrix, 3 = always zero). rd_data is valid with rd_vld one cycle later. With rd_clr the entry is zeroed after it is read. A single-channel address at or above SGL_BINS reads as zero and clears nothing.
- R10: After reset rate_a, rate_b and rate_c are zero, and rate_stb and rd_vld are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_en | input | 1 | Acquisition enable |
| smp_vld | input | 1 | Sample strobe from the extractors |
| amp_a | input | AMP_W | Channel A amplitude, 0 = no pulse |
| amp_b | input | AMP_W | Channel B amplitude, 0 = no pulse |
| rd_en | input | 1 | Readout request |
| rd_sel | input | 2 | Readout target |
| rd_addr | input | RD_AW | Readout address |
| rd_clr | input | 1 | Zero the entry after reading it |
| rd_vld | output | 1 | rd_data is valid |
| rd_data | output | CNT_W | Readout value |
| rate_stb | output | 1 | One-cycle pulse marking a new rate result |
| rate_a | output | RATE_W | Channel A strong-pulse count of the last window |
| rate_b | output | RATE_W | Channel B strong-pulse count of the last window |
| rate_c | output | RATE_W | Strong-coincidence count of the last window |

## Verification
The bench drives the exact edges of every window, so that an off-by-one error shows up in the results. On the index side it uses bin 0, the last valid bin and the first bin past the end. On the matrix side it uses coordinate 63 against 64, and it sits right on both rate thresholds, where a design that uses >= instead of > would count the extra samples. It also sends pairs with one zero amplitude, which a loose coincidence test would wrongly bin.

A long run of identical samples tests two things. It exposes a read-modify-write pipeline without forwarding, whose count would fall behind, and a counter that wraps to zero instead of holding at its maximum. Paused and strobe-less samples, together with windows broken by gaps, catch a design that counts rejected samples or loses the last sample of a window. A read-then-reread pass shows whether the clear really takes effect.

// File: rtl/chist_pkg.sv
package chist_pkg;

  typedef enum logic [1:0] {
    SEL_CHA  = 2'd0,
    SEL_CHB  = 2'd1,
    SEL_MTX  = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/chist_chan.sv
// Per-channel amplitude classification: fine index, coarse coordinate,
// bounds and rate-threshold flags.
module chist_chan #(
  parameter int AMP_W         = 17,
  parameter int SGL_DIV       = 100,
  parameter int SGL_BINS      = 512,
  parameter int COIN_DIV      = 1500,
  parameter int COIN_DIM      = 64,
  parameter int SGL_RATE_MIN  = 60,
  parameter int COIN_RATE_MIN = 6,
  localparam int SGL_AW = $clog2(SGL_BINS),
  localparam int DIM_W  = $clog2(COIN_DIM)
) (
  input  logic [AMP_W-1:0]  amp,
  output logic              nz,
  output logic [SGL_AW-1:0] sgl_idx,
  output logic              sgl_ok,
  output logic              sgl_rate,
  output logic [DIM_W-1:0]  crd,
  output logic              crd_ok,
  output logic              crd_rate
);

  function automatic logic [AMP_W-1:0] scale_amp(input logic [AMP_W-1:0] a,
                                                 input int unsigned d);
    return a / AMP_W'(d);
  endfunction

  logic [AMP_W-1:0] sgl_full;
  logic [AMP_W-1:0] crd_full;

  assign sgl_full = scale_amp(amp, SGL_DIV);
  assign crd_full = scale_amp(amp, COIN_DIV);
  assign nz       = (amp != '0);

  assign sgl_idx  = sgl_full[SGL_AW-1:0];
  assign sgl_ok   = (sgl_full != '0) && (32'(sgl_full) < 32'(SGL_BINS));
  assign sgl_rate = 32'(sgl_full) > 32'(SGL_RATE_MIN);

  assign crd      = crd_full[DIM_W-1:0];
  assign crd_ok   = 32'(crd_full) < 32'(COIN_DIM);
  assign crd_rate = 32'(crd_full) > 32'(COIN_RATE_MIN);

endmodule

// File: rtl/chist_bank.sv
// Histogram RAM with a two-stage saturating read-modify-write and
// same-address forwarding; second use of the write port is read-and-clear.
module chist_bank #(
  parameter int DEPTH = 512,
  parameter int CNT_W = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_vld,
  input  logic [AW-1:0]    inc_addr,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  input  logic             rd_clr,
  output logic [CNT_W-1:0] rd_data
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CMAX) ? v : v + 1'b1;
  endfunction

  logic [CNT_W-1:0] mem [DEPTH];
  logic             p1_vld;
  logic [AW-1:0]    p1_addr;
  logic [CNT_W-1:0] p1_val;
  logic [CNT_W-1:0] nv;
  logic             fwd;

  assign nv  = sat_inc(p1_val);
  assign fwd = p1_vld && inc_vld && (inc_addr == p1_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_vld  <= 1'b0;
      p1_addr <= '0;
    end else begin
      p1_vld  <= inc_vld;
      p1_addr <= inc_addr;
    end
  end

  // Data path: no reset on RAM or its read registers.
  always_ff @(posedge clk) begin
    p1_val  <= fwd ? nv : mem[inc_addr];
    rd_data <= mem[rd_addr];
    if (p1_vld)
      mem[p1_addr] <= nv;
    else if (rd_en && rd_clr)
      mem[rd_addr] <= '0;
  end

  // R3: a committed increment never leaves the bin at zero
  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    p1_vld |=> (mem[$past(p1_addr)] != '0));

  // R4: a forwarded hit builds on the value just written, not on stale RAM
  assert_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fwd |=> ((p1_val == CMAX) || (p1_val == $past(p1_val) + 1'b1)));

endmodule

// File: rtl/chist_rate.sv
// Windowed counters: count hits over PERIOD accepted samples, publish, restart.
module chist_rate #(
  parameter int PERIOD = 192000,
  localparam int RW  = $clog2(PERIOD + 1),
  localparam int SCW = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp,
  input  logic [2:0]    hit,
  output logic          stb,
  output logic [RW-1:0] rate [3]
);

  logic [SCW-1:0] scnt;
  logic [RW-1:0]  acc [3];
  logic           wrap;

  assign wrap = smp && (scnt == SCW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt <= '0;
      stb  <= 1'b0;
    end else begin
      stb <= wrap;
      if (smp) scnt <= wrap ? '0 : scnt + 1'b1;
    end
  end

  for (genvar k = 0; k < 3; k++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc[k]  <= '0;
        rate[k] <= '0;
      end else if (wrap) begin
        rate[k] <= acc[k] + RW'(hit[k]);
        acc[k]  <= '0;
      end else if (smp && hit[k]) begin
        acc[k]  <= acc[k] + 1'b1;
      end
    end
  end

  // R7: the publish strobe lasts one cycle
  assert_stb_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);

  // R7: a publish always follows an accepted sample
  assert_stb_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> $past(smp));

  // R8: without an accepted sample the window position holds
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !smp |=> $stable(scnt));

endmodule

// File: rtl/coinc_hist.sv
module coinc_hist
  import chist_pkg::*;
#(
  parameter int AMP_W         = 17,
  parameter int SGL_DIV       = 100,
  parameter int SGL_BINS      = 512,
  parameter int COIN_DIV      = 1500,
  parameter int COIN_DIM      = 64,
  parameter int CNT_W         = 16,
  parameter int SGL_RATE_MIN  = 60,
  parameter int COIN_RATE_MIN = 6,
  parameter int RATE_PERIOD   = 192000,
  localparam int SGL_AW = $clog2(SGL_BINS),
  localparam int DIM_W  = $clog2(COIN_DIM),
  localparam int MTX_AW = 2 * DIM_W,
  localparam int RD_AW  = imax(SGL_AW, MTX_AW),
  localparam int RATE_W = $clog2(RATE_PERIOD + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acq_en,
  input  logic              smp_vld,
  input  logic [AMP_W-1:0]  amp_a,
  input  logic [AMP_W-1:0]  amp_b,
  input  logic              rd_en,
  input  logic [1:0]        rd_sel,
  input  logic [RD_AW-1:0]  rd_addr,
  input  logic              rd_clr,
  output logic              rd_vld,
  output logic [CNT_W-1:0]  rd_data,
  output logic              rate_stb,
  output logic [RATE_W-1:0] rate_a,
  output logic [RATE_W-1:0] rate_b,
  output logic [RATE_W-1:0] rate_c
);

  // Named internal events
  logic              acc_smp;
  logic              coin_evt;
  logic              coin_bin;
  logic              coin_rate;
  logic [AMP_W-1:0]  amp_v    [2];
  logic              nz       [2];
  logic [SGL_AW-1:0] sgl_idx  [2];
  logic              sgl_ok   [2];
  logic              sgl_rate [2];
  logic [DIM_W-1:0]  crd      [2];
  logic              crd_ok   [2];
  logic              crd_rate [2];
  logic [CNT_W-1:0]  sgl_rd   [2];
  logic [CNT_W-1:0]  mtx_rd;
  logic [RATE_W-1:0] rate_v   [3];
  logic              rd_sgl_ok;
  rd_sel_e           sel_now;
  rd_sel_e           sel_q;
  logic              oob_q;

  assign amp_v[0] = amp_a;
  assign amp_v[1] = amp_b;
  assign acc_smp  = acq_en && smp_vld;
  assign sel_now  = rd_sel_e'(rd_sel);
  assign rd_sgl_ok = (rd_addr >> SGL_AW) == '0;

  for (genvar g = 0; g < 2; g++) begin : g_ch
    chist_chan #(
      .AMP_W(AMP_W), .SGL_DIV(SGL_DIV), .SGL_BINS(SGL_BINS),
      .COIN_DIV(COIN_DIV), .COIN_DIM(COIN_DIM),
      .SGL_RATE_MIN(SGL_RATE_MIN), .COIN_RATE_MIN(COIN_RATE_MIN)
    ) u_chan (
      .amp(amp_v[g]), .nz(nz[g]), .sgl_idx(sgl_idx[g]), .sgl_ok(sgl_ok[g]),
      .sgl_rate(sgl_rate[g]), .crd(crd[g]), .crd_ok(crd_ok[g]),
      .crd_rate(crd_rate[g])
    );

    chist_bank #(.DEPTH(SGL_BINS), .CNT_W(CNT_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .inc_vld(acc_smp && sgl_ok[g]), .inc_addr(sgl_idx[g]),
      .rd_en(rd_en && (sel_now == rd_sel_e'(g)) && rd_sgl_ok),
      .rd_addr(rd_addr[SGL_AW-1:0]), .rd_clr(rd_clr),
      .rd_data(sgl_rd[g])
    );
  end

  assign coin_evt  = acc_smp && nz[0] && nz[1];
  assign coin_bin  = coin_evt && crd_ok[0] && crd_ok[1];
  assign coin_rate = coin_evt && crd_rate[0] && crd_rate[1];

  chist_bank #(.DEPTH(COIN_DIM * COIN_DIM), .CNT_W(CNT_W)) u_mtx (
    .clk(clk), .rst_n(rst_n),
    .inc_vld(coin_bin), .inc_addr({crd[0], crd[1]}),
    .rd_en(rd_en && (sel_now == SEL_MTX)),
    .rd_addr(rd_addr[MTX_AW-1:0]), .rd_clr(rd_clr),
    .rd_data(mtx_rd)
  );

  chist_rate #(.PERIOD(RATE_PERIOD)) u_rate (
    .clk(clk), .rst_n(rst_n), .smp(acc_smp),
    .hit({coin_rate, sgl_rate[1], sgl_rate[0]}),
    .stb(rate_stb), .rate(rate_v)
  );

  assign rate_a = rate_v[0];
  assign rate_b = rate_v[1];
  assign rate_c = rate_v[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld <= 1'b0;
      sel_q  <= SEL_NONE;
      oob_q  <= 1'b0;
    end else begin
      rd_vld <= rd_en;
      sel_q  <= sel_now;
      oob_q  <= !rd_sgl_ok;
    end
  end

  always_comb begin
    case (sel_q)
      SEL_CHA: rd_data = oob_q ? '0 : sgl_rd[0];
      SEL_CHB: rd_data = oob_q ? '0 : sgl_rd[1];
      SEL_MTX: rd_data = mtx_rd;
      default: rd_data = '0;
    endcase
  end

  // R9: every request yields a valid response one cycle later
  assert_rd_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_vld);

  // R6: when a strong coincidence implies two strong singles, its count
  // can never exceed either single-channel count
  if (COIN_DIV * (COIN_RATE_MIN + 1) >= SGL_DIV * (SGL_RATE_MIN + 1)) begin : g_rate_order
    assert_coin_le_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rate_stb |-> ((rate_c <= rate_a) && (rate_c <= rate_b)));
  end

endmodule

// File: tb/sim_coinc_hist.sv
module sim_coinc_hist;
  localparam int AMP_W = 17;
  localparam int SB    = 512;
  localparam int DIM   = 64;
  localparam int CW    = 10;
  localparam int PER   = 50;
  localparam int RW    = $clog2(PER + 1);
  localparam int AW    = 12;
  localparam int CMAX  = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic             acq_en = 0, smp_vld = 0, rd_en = 0, rd_clr = 0;
  logic [AMP_W-1:0] amp_a = '0, amp_b = '0;
  logic [1:0]       rd_sel = '0;
  logic [AW-1:0]    rd_addr = '0;
  logic             rd_vld, rate_stb;
  logic [CW-1:0]    rd_data;
  logic [RW-1:0]    rate_a, rate_b, rate_c;

  coinc_hist #(.CNT_W(CW), .RATE_PERIOD(PER)) u0 (
    .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .smp_vld(smp_vld),
    .amp_a(amp_a), .amp_b(amp_b), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_addr(rd_addr), .rd_clr(rd_clr), .rd_vld(rd_vld), .rd_data(rd_data),
    .rate_stb(rate_stb), .rate_a(rate_a), .rate_b(rate_b), .rate_c(rate_c)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int mdl_a [SB];
  int mdl_b [SB];
  int mdl_m [DIM*DIM];
  int    rq[$];
  string rtag[$];
  int eq_a[$], eq_b[$], eq_c[$];
  int win_n = 0, win_a = 0, win_b = 0, win_c = 0;
  bit prev_stb = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bump(input int v);
    return (v >= CMAX) ? CMAX : v + 1;
  endfunction

  // Reference model, from the requirements
  task automatic model(input int a, input int b);
    int fa, fb, x, y;
    fa = a / 100; fb = b / 100;
    if (fa >= 1 && fa <= SB - 1) mdl_a[fa] = bump(mdl_a[fa]);
    if (fb >= 1 && fb <= SB - 1) mdl_b[fb] = bump(mdl_b[fb]);
    x = a / 1500; y = b / 1500;
    if (a != 0 && b != 0 && x <= DIM - 1 && y <= DIM - 1)
      mdl_m[x*DIM + y] = bump(mdl_m[x*DIM + y]);
    if (fa >= 61) win_a++;
    if (fb >= 61) win_b++;
    if (a != 0 && b != 0 && x >= 7 && y >= 7) win_c++;
    win_n++;
    if (win_n == PER) begin
      eq_a.push_back(win_a); eq_b.push_back(win_b); eq_c.push_back(win_c);
      win_n = 0; win_a = 0; win_b = 0; win_c = 0;
    end
  endtask

  task automatic put(input int a, input int b, input bit en = 1, input bit vld = 1);
    @(posedge clk); #1;
    acq_en = en; smp_vld = vld; amp_a = AMP_W'(a); amp_b = AMP_W'(b);
    if (en && vld) model(a, b);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      acq_en = 0; smp_vld = 0; amp_a = '0; amp_b = '0;
    end
  endtask

  task automatic rd(input int sel, input int addr, input bit clr, input int exp, input string tag);
    @(posedge clk); #1;
    rd_en = 1; rd_sel = 2'(sel); rd_addr = AW'(addr); rd_clr = clr;
    rq.push_back(exp); rtag.push_back(tag);
  endtask

  task automatic rd_stop();
    @(posedge clk); #1;
    rd_en = 0; rd_clr = 0;
  endtask

  function automatic string tag_of(input int sel, input int addr);
    if (sel == 0 && addr == 7) return "R3";
    if ((sel == 0 && addr == 30) || (sel == 1 && addr == 45) || (sel == 2 && addr == 2*DIM+3))
      return "R4";
    if ((sel == 0 && (addr == 300 || addr == 310)) || (sel == 1 && addr == 320) ||
        (sel == 2 && addr == 20*DIM+21))
      return "R8";
    return (sel == 2) ? "R2" : "R1";
  endfunction

  // Monitor: compare results as they come out
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rd_vld) begin
        if (rq.size() == 0) check(0, "R9 unexpected rd_vld", 1, 0);
        else begin
          int e; string t;
          e = rq.pop_front(); t = rtag.pop_front();
          if (e >= 0) check(rd_data == CW'(e), t, rd_data, e);
        end
      end
      if (rate_stb) begin
        check(!prev_stb, "R7 strobe longer than one cycle", 1, 0);
        if (eq_a.size() == 0) check(0, "R7 unexpected rate_stb", 1, 0);
        else begin
          int ea, eb, ec;
          ea = eq_a.pop_front(); eb = eq_b.pop_front(); ec = eq_c.pop_front();
          check(rate_a == RW'(ea), "R5 rate_a", rate_a, ea);
          check(rate_b == RW'(eb), "R5 rate_b", rate_b, eb);
          check(rate_c == RW'(ec), "R6 rate_c", rate_c, ec);
        end
      end
      prev_stb = rate_stb;
    end
  end

  initial begin
    #(1_000_000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    foreach (mdl_a[i]) mdl_a[i] = 0;
    foreach (mdl_b[i]) mdl_b[i] = 0;
    foreach (mdl_m[i]) mdl_m[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check(rate_a == 0, "R10 rate_a", rate_a, 0);
    check(rate_b == 0, "R10 rate_b", rate_b, 0);
    check(rate_c == 0, "R10 rate_c", rate_c, 0);
    check(rate_stb == 0, "R10 rate_stb", rate_stb, 0);
    check(rd_vld == 0, "R10 rd_vld", rd_vld, 0);

    // Zero all RAM contents (no compare)
    for (int s = 0; s < 3; s++)
      for (int a = 0; a < ((s == 2) ? DIM*DIM : SB); a++) rd(s, a, 1, -1, "init");
    rd_stop();
    idle(3);

    // R1 index edges, R5 threshold edges
    put(250, 0);       put(99, 0);       put(51199, 0);   put(51200, 6100);
    put(0, 6099);      put(6100, 6000);
    // R2 coincidence edges, R6 threshold edges
    put(10500, 10500); put(10499, 20000); put(95999, 1500); put(96000, 3000);
    put(0, 5000);      put(4000, 0);      put(1499, 1499);
    // R8 rejected samples
    put(30000, 32000, 1, 0);
    put(31000, 32000, 0, 1);
    put(30000, 32000, 0, 0);
    // R4 back-to-back on the same bins, also alternating
    for (int i = 0; i < 5; i++) put(3000, 4500);
    for (int i = 0; i < 4; i++) put((i % 2) ? 3000 : 3100, 4500);
    idle(2);
    // R3 saturation
    for (int i = 0; i < CMAX + 7; i++) put(700, 0);
    // Mixed pattern across many windows, with gaps
    for (int i = 0; i < 300; i++) begin
      put((i * 337) % 70000, (i * 911 + 50) % 70000, 1, (i % 7) != 3);
    end
    idle(5);

    // Full dump with clear
    for (int s = 0; s < 3; s++)
      for (int a = 0; a < ((s == 2) ? DIM*DIM : SB); a++)
        rd(s, a, 1, (s == 0) ? mdl_a[a] : (s == 1) ? mdl_b[a] : mdl_m[a], tag_of(s, a));
    // R9 cleared entries read zero, out-of-range and sel 3 read zero
    rd(0, 7, 0, 0, "R9 cleared A");
    rd(1, 45, 0, 0, "R9 cleared B");
    rd(2, 2*DIM+3, 0, 0, "R9 cleared M");
    rd(3, 5, 0, 0, "R9 sel none");
    rd_stop();
    // R9 out-of-range single read returns zero and leaves bin intact
    put(1200, 0);
    idle(4);
    rd(0, SB + 12, 1, 0, "R9 out of range");
    rd(0, 12, 0, 1, "R9 bin untouched by out-of-range clear");
    rd_stop();
    idle(4);

    check(rq.size() == 0, "R9 outstanding reads", rq.size(), 0);
    check(eq_a.size() == 0, "R7 missing rate strobes", eq_a.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule